// File: doc/BRIEF.md
# Far-End Fault Signalling Unit

This block carries a link failure in-band on a 100 Mb/s fibre link, which has no auto-negotiation. On the transmit side it sits between the normal code-group serializer input and the line. While the local receiver reports a channel failure and the function is enabled, it replaces the outgoing bit stream with a repeating fault pattern. The pattern is eighty-four ones followed by one zero, so each period is 85 bits.

On the receive side it watches the incoming bit stream whenever signal-detect is asserted. It counts complete fault patterns. After three back-to-back patterns it tells the link monitor to drop the link. It also sets a sticky status bit for software, which a read strobe clears once the condition has gone away. The enable comes out of reset according to the operating mode: on for fibre, off for twisted-pair operation at either speed. Software can overwrite it at any time.

Top module: `fefUnit`

## Requirements
- R1: While rstN is low, the enable takes the value 1 when opMode is 2'b10 (100 Mb/s fibre). It takes 0 for 2'b00 (10 Mb/s twisted pair), 2'b01 (100 Mb/s twisted pair) and 2'b11. fefEnable shows the enable.
- R2: When enWrite is sampled high, enValue is loaded into the enable at that clock edge, and fefEnable shows the new value right after that edge.
- R3: When enable and rxFail are sampled high, txOut is driven one clock later with the fault pattern: 84 ones, then one zero, repeated. The pattern starts with the first one on the first such cycle.
- R4: When rxFail is sampled low, txOut equals txIn delayed by one clock.
- R5: A pattern match is a zero on rxIn preceded by exactly 84 consecutive ones, all sampled with signal-detect high. forceLinkFail goes high right after the clock edge that samples the zero ending the third consecutive match. It stays high until the count is broken.
- R6: A zero that ends a run of ones of any other length (fewer than 84, or more than 84) restarts the match count at zero. This drops forceLinkFail right after that edge.
- R7: A cycle with sigDetect low clears the run of ones and the match count, so three new full patterns are then needed.
- R8: remoteFault goes high one clock after forceLinkFail is high. It stays high after the condition ends until statusRead is sampled high while the condition is absent.
- R9: statusRead sampled while forceLinkFail is high does not clear remoteFault.
- R10: While the enable is 0, txOut passes txIn even with rxFail high, and forceLinkFail and remoteFault are 0 from the edge at which the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Synchronous active-low reset |
| opMode | input | 2 | Operating mode, sampled during reset for the enable default |
| enWrite | input | 1 | Software write strobe for the enable |
| enValue | input | 1 | Value loaded into the enable on enWrite |
| rxFail | input | 1 | Local receive-channel failure |
| txIn | input | 1 | Bit from the normal transmit path |
| txOut | output | 1 | Bit to the line (registered) |
| sigDetect | input | 1 | Valid receive signal present |
| rxIn | input | 1 | Bit from the line |
| statusRead | input | 1 | Read strobe that clears the sticky status |
| fefEnable | output | 1 | Current enable state |
| forceLinkFail | output | 1 | Forces the link monitor to fail |
| remoteFault | output | 1 | Sticky remote fault status |

## Verification
txOut is due one rising edge after the inputs it depends on. forceLinkFail and fefEnable change right after the edge that samples the terminating zero or the write strobe. remoteFault trails forceLinkFail by one further edge. The bench changes inputs only on falling edges. A reference model advances once per rising edge, and every output is compared at the next falling edge, so each comparison falls in the cycle where that output is due. The directed checks are placed by the same rule, for example remoteFault is examined one tick after the third pattern's zero.

// File: rtl/fefPkg.sv
package fefPkg;
  typedef enum logic [1:0] {
    MODE_TP10   = 2'b00,
    MODE_TP100  = 2'b01,
    MODE_FIBRE  = 2'b10,
    MODE_RSVD   = 2'b11
  } linkMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic sendFault;  // substitute the fault pattern on transmit
    logic rxHold;     // suspend receive monitoring, clear the run
  } fefCtl_t;

  // datapath -> control receive events
  typedef struct packed {
    logic matchEnd;   // zero closing a run of exactly the pattern length
    logic breakEnd;   // zero closing any other run
  } fefRxEvt_t;
endpackage

// File: rtl/fefDatapath.sv
module fefDatapath
  import fefPkg::*;
#(
  parameter int ONES_LEN = 84
) (
  input  logic      clk,
  input  logic      rstN,
  input  fefCtl_t   ctl,
  input  logic      txIn,
  input  logic      rxIn,
  output logic      txOut,
  output fefRxEvt_t rxEvt
);
  localparam int CW = $clog2(ONES_LEN + 2);
  localparam logic [CW-1:0] RUN_FULL = CW'(ONES_LEN);
  localparam logic [CW-1:0] RUN_OVER = CW'(ONES_LEN + 1);

  logic [CW-1:0] txPos;
  logic [CW-1:0] rxRun;

  // transmit: pattern generator muxed with the normal stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPos <= '0;
      txOut <= 1'b0;
    end else if (ctl.sendFault) begin
      txOut <= (txPos != RUN_FULL);
      txPos <= (txPos == RUN_FULL) ? '0 : txPos + 1'b1;
    end else begin
      txOut <= txIn;
      txPos <= '0;
    end
  end

  // receive: run length of ones, saturating one past the pattern length
  always_ff @(posedge clk) begin
    if (!rstN || ctl.rxHold) begin
      rxRun <= '0;
    end else if (rxIn) begin
      if (rxRun != RUN_OVER) rxRun <= rxRun + 1'b1;
    end else begin
      rxRun <= '0;
    end
  end

  always_comb begin
    rxEvt.matchEnd = !ctl.rxHold && !rxIn && (rxRun == RUN_FULL);
    rxEvt.breakEnd = !ctl.rxHold && !rxIn && (rxRun != RUN_FULL);
  end
endmodule

// File: rtl/fefCtrl.sv
module fefCtrl
  import fefPkg::*;
#(
  parameter int CONFIRM_COUNT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] opMode,
  input  logic      enWrite,
  input  logic      enValue,
  input  logic      rxFail,
  input  logic      sigDetect,
  input  logic      statusRead,
  input  fefRxEvt_t rxEvt,
  output fefCtl_t   ctl,
  output logic      fefEnable,
  output logic      forceLinkFail,
  output logic      remoteFault
);
  localparam int HW = $clog2(CONFIRM_COUNT + 1);
  localparam logic [HW-1:0] HIT_MAX = HW'(CONFIRM_COUNT);

  logic          enReg;
  logic [HW-1:0] hitCnt;
  logic          faultSeen;
  logic          statusLatch;

  assign faultSeen = (hitCnt == HIT_MAX);

  // enable: mode-dependent default under reset, software overwrite after
  always_ff @(posedge clk) begin
    if (!rstN)        enReg <= (opMode == MODE_FIBRE);
    else if (enWrite) enReg <= enValue;
  end

  // consecutive pattern counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.rxHold) begin
      hitCnt <= '0;
    end else if (rxEvt.matchEnd) begin
      if (hitCnt != HIT_MAX) hitCnt <= hitCnt + 1'b1;
    end else if (rxEvt.breakEnd) begin
      hitCnt <= '0;
    end
  end

  // sticky status, cleared by a read only once the condition is gone
  always_ff @(posedge clk) begin
    if (!rstN || !enReg) statusLatch <= 1'b0;
    else                 statusLatch <= faultSeen | (statusLatch & ~statusRead);
  end

  always_comb begin
    ctl.sendFault = enReg & rxFail;
    ctl.rxHold    = ~enReg | ~sigDetect;
  end

  assign fefEnable     = enReg;
  assign forceLinkFail = faultSeen & enReg;
  assign remoteFault   = statusLatch & enReg;
endmodule

// File: rtl/fefUnit.sv
module fefUnit
  import fefPkg::*;
#(
  parameter int ONES_LEN      = 84,
  parameter int CONFIRM_COUNT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] opMode,
  input  logic       enWrite,
  input  logic       enValue,
  input  logic       rxFail,
  input  logic       txIn,
  output logic       txOut,
  input  logic       sigDetect,
  input  logic       rxIn,
  input  logic       statusRead,
  output logic       fefEnable,
  output logic       forceLinkFail,
  output logic       remoteFault
);
  fefCtl_t   ctl;
  fefRxEvt_t rxEvt;

  fefCtrl #(.CONFIRM_COUNT(CONFIRM_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .opMode(opMode),
    .enWrite(enWrite), .enValue(enValue),
    .rxFail(rxFail), .sigDetect(sigDetect), .statusRead(statusRead),
    .rxEvt(rxEvt), .ctl(ctl),
    .fefEnable(fefEnable), .forceLinkFail(forceLinkFail),
    .remoteFault(remoteFault)
  );

  fefDatapath #(.ONES_LEN(ONES_LEN)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .txIn(txIn), .rxIn(rxIn),
    .txOut(txOut), .rxEvt(rxEvt)
  );
endmodule

// File: rtl/fefChecker.sv
module fefChecker (
  input logic clk,
  input logic rstN,
  input logic enWrite,
  input logic rxFail,
  input logic txIn,
  input logic txOut,
  input logic sigDetect,
  input logic statusRead,
  input logic fefEnable,
  input logic forceLinkFail,
  input logic remoteFault
);
  // R3: inside the fault pattern a zero is always followed by a one
  assert_zero_then_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fefEnable && rxFail && !txOut) |=> txOut);

  // R4: no failure means the normal stream goes out one clock later
  assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rxFail |=> (txOut == $past(txIn)));

  // R7: losing signal-detect removes the link-fail force
  assert_no_signal_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sigDetect |=> !forceLinkFail);

  // R8: a forced link fail is recorded in the status one clock later
  assert_status_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (forceLinkFail && !enWrite) |=> remoteFault);

  // R8: the status holds until a read
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (remoteFault && !statusRead && !enWrite) |=> remoteFault);

  // R10: disabled block passes the transmit stream
  assert_disabled_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    !fefEnable |=> (txOut == $past(txIn)));
endmodule

bind fefUnit fefChecker u_fefChecker (
  .clk(clk), .rstN(rstN), .enWrite(enWrite), .rxFail(rxFail),
  .txIn(txIn), .txOut(txOut), .sigDetect(sigDetect),
  .statusRead(statusRead), .fefEnable(fefEnable),
  .forceLinkFail(forceLinkFail), .remoteFault(remoteFault)
);

// File: tb/tb_fefUnit.sv
module tb_fefUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] opMode = 2'b10;
  logic enWrite = 1'b0, enValue = 1'b0, rxFail = 1'b0, txIn = 1'b0;
  logic sigDetect = 1'b0, rxIn = 1'b0, statusRead = 1'b0;
  logic txOut, fefEnable, forceLinkFail, remoteFault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit mEn, mTxOut, mLatch, mSend;
  int mTxPos, mRun, mHits;

  always #2 clk = ~clk;  // 250 MHz

  fefUnit dut (
    .clk(clk), .rstN(rstN), .opMode(opMode), .enWrite(enWrite),
    .enValue(enValue), .rxFail(rxFail), .txIn(txIn), .txOut(txOut),
    .sigDetect(sigDetect), .rxIn(rxIn), .statusRead(statusRead),
    .fefEnable(fefEnable), .forceLinkFail(forceLinkFail),
    .remoteFault(remoteFault)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelUpdate();
    bit send, hold, good, bad, ff;
    if (!rstN) begin
      mEn = (opMode == 2'b10);
      mTxPos = 0; mTxOut = 0; mRun = 0; mHits = 0; mLatch = 0; mSend = 0;
    end else begin
      send = mEn && rxFail;
      hold = !mEn || !sigDetect;
      good = !hold && !rxIn && (mRun == 84);
      bad  = !hold && !rxIn && (mRun != 84);
      ff   = (mHits == 3);
      mLatch = !mEn ? 1'b0 : (ff || (mLatch && !statusRead));
      if (send) begin
        mTxOut = (mTxPos != 84);
        mTxPos = (mTxPos == 84) ? 0 : mTxPos + 1;
      end else begin
        mTxOut = txIn;
        mTxPos = 0;
      end
      if (hold) mRun = 0;
      else if (rxIn) mRun = (mRun < 85) ? mRun + 1 : 85;
      else mRun = 0;
      if (hold) mHits = 0;
      else if (good) mHits = (mHits < 3) ? mHits + 1 : 3;
      else if (bad) mHits = 0;
      mSend = send;
      if (enWrite) mEn = enValue;
    end
  endtask

  task automatic compareAll();
    check(fefEnable == mEn, "R2 fefEnable", fefEnable, mEn);
    check(txOut == mTxOut, mSend ? "R3 txOut" : "R4 txOut", txOut, mTxOut);
    check(forceLinkFail == (mEn && mHits == 3), "R5 forceLinkFail",
          forceLinkFail, (mEn && mHits == 3));
    check(remoteFault == (mEn && mLatch), "R8 remoteFault", remoteFault, (mEn && mLatch));
  endtask

  // inputs change at a falling edge; outputs checked at the next falling edge
  task automatic tick();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll();
  endtask

  task automatic rxBit(input logic b);
    rxIn = b;
    tick();
  endtask

  task automatic rxPattern(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (84) rxBit(1'b1);
      rxBit(1'b0);
    end
  endtask

  task automatic doReset(input logic [1:0] m);
    rstN = 1'b0; opMode = m;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int pos;
    void'($urandom(32'h00C0FFEE));
    @(negedge clk);

    // R1: mode-dependent enable default
    doReset(2'b01); check(fefEnable == 1'b0, "R1 tp100 default", fefEnable, 0);
    doReset(2'b00); check(fefEnable == 1'b0, "R1 tp10 default", fefEnable, 0);
    doReset(2'b10); check(fefEnable == 1'b1, "R1 fibre default", fefEnable, 1);
    check(txOut == 1'b0 && forceLinkFail == 1'b0 && remoteFault == 1'b0,
          "R1 reset outputs", {txOut, forceLinkFail, remoteFault}, 0);

    // R3: transmit substitution
    sigDetect = 1'b1;
    rxFail = 1'b1;
    for (int i = 0; i < 200; i++) begin
      txIn = 1'(($urandom() % 2));
      tick();
      check(txOut == ((i % 85) != 84), "R3 pattern bit", txOut, ((i % 85) != 84));
    end
    rxFail = 1'b0;
    for (int i = 0; i < 20; i++) begin txIn = 1'($urandom() % 2); tick(); end

    // R5 / R8: three consecutive patterns
    rxBit(1'b0);
    rxPattern(2);
    check(forceLinkFail == 1'b0, "R5 two patterns", forceLinkFail, 0);
    rxPattern(1);
    check(forceLinkFail == 1'b1, "R5 third pattern", forceLinkFail, 1);
    check(remoteFault == 1'b0, "R8 status lags", remoteFault, 0);
    rxBit(1'b1);
    check(remoteFault == 1'b1, "R8 status set", remoteFault, 1);

    // R6: short run breaks, status stays until read
    repeat (9) rxBit(1'b1);
    rxBit(1'b0);
    check(forceLinkFail == 1'b0, "R6 short run", forceLinkFail, 0);
    check(remoteFault == 1'b1, "R8 sticky", remoteFault, 1);
    statusRead = 1'b1; rxBit(1'b0); statusRead = 1'b0;
    check(remoteFault == 1'b0, "R8 read clears", remoteFault, 0);

    // R9: read while active does not clear
    rxPattern(3);
    rxBit(1'b1);
    statusRead = 1'b1; rxBit(1'b1); statusRead = 1'b0;
    check(remoteFault == 1'b1, "R9 read while active", remoteFault, 1);

    // R6: over-long run breaks
    repeat (90) rxBit(1'b1);
    rxBit(1'b0);
    check(forceLinkFail == 1'b0, "R6 long run", forceLinkFail, 0);

    // R7: signal loss restarts the count
    rxPattern(2);
    sigDetect = 1'b0; rxBit(1'b0); sigDetect = 1'b1;
    rxPattern(1);
    check(forceLinkFail == 1'b0, "R7 restart after loss", forceLinkFail, 0);
    rxPattern(2);
    check(forceLinkFail == 1'b1, "R7 three after loss", forceLinkFail, 1);
    rxBit(1'b1);

    // R10: disable
    enWrite = 1'b1; enValue = 1'b0; rxBit(1'b1); enWrite = 1'b0;
    check(fefEnable == 1'b0, "R2 write zero", fefEnable, 0);
    check(forceLinkFail == 1'b0, "R10 no force", forceLinkFail, 0);
    check(remoteFault == 1'b0, "R10 no status", remoteFault, 0);
    rxFail = 1'b1;
    for (int i = 0; i < 10; i++) begin
      logic b;
      b = 1'(i % 2);
      txIn = b;
      tick();
      check(txOut == b, "R10 pass while disabled", txOut, b);
    end
    rxBit(1'b0);
    rxPattern(3);
    check(forceLinkFail == 1'b0, "R10 patterns ignored", forceLinkFail, 0);
    check(remoteFault == 1'b0, "R10 status quiet", remoteFault, 0);
    rxFail = 1'b0;
    enWrite = 1'b1; enValue = 1'b1; tick(); enWrite = 1'b0;
    check(fefEnable == 1'b1, "R2 write one", fefEnable, 1);

    // constrained random phase
    pos = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom() % 40 == 0) rxFail = ~rxFail;
      txIn = 1'($urandom() % 2);
      sigDetect = ($urandom() % 600 != 0);
      statusRead = ($urandom() % 50 == 0);
      enWrite = ($urandom() % 900 == 0);
      enValue = ($urandom() % 4 != 0);
      if ($urandom() % 4 != 0) begin
        rxIn = (pos != 84);
        if ($urandom() % 400 == 0) rxIn = ~rxIn;
      end else begin
        rxIn = 1'($urandom() % 2);
      end
      pos = (pos == 84) ? 0 : pos + 1;
      tick();
    end
    enWrite = 1'b0; statusRead = 1'b0;
    finishRun();
  end
endmodule